// File: doc/BRIEF.md
# Frame-Synchronised Control Register Bank

This block holds the run-time parameters of a video scaling engine behind a simple 32-bit register port. Software may write the parameter registers at any point in a frame. Those writes land in a shadow copy. The copy is moved into the active outputs only once per frame, on the first cycle in which the vertical blanking input is seen high after being low. The scaling datapath therefore always runs a whole frame on one coherent parameter set.

Alongside the parameters sits a small interrupt controller. Five event sources set sticky pending bits: frame completed, input overrun, output underrun, parameters committed and coefficient write refused. Software reads a pending bit to find the cause and writes a one to it to clear it. A per-source enable mask and a global enable gate these bits onto a single interrupt line. A keyed write to a reset register returns every register to zero. Reads are combinational from the address.

Top module: `vsync_regbank`

## Requirements
- R1: After the reset input is released, every readable register returns 0, the active outputs are 0 and `irq_o` is 0.
- R2: The parameter words sit at 0x10 + 4*k for k = 0..10, in this order: k0 horizontal shrink factor (24 bits), k1 vertical shrink factor (24 bits), k2 horizontal aperture, k3 vertical aperture, k4 output size (all three with start/width in bits 10:0 and end/height in bits 26:16), k5 phase counts (horizontal 6:0, vertical 22:16), k6 coefficient set selects (horizontal 3:0, vertical 19:16), k7..k10 four start-phase values (21 bits). A read returns the written value with all bits outside these fields cleared.
- R3: The active outputs change only on the clock edge where `vblank_i` is high and was low at the previous edge. On that edge they take the shadow values held before it, so a parameter write on that same edge applies only to the next frame.
- R4: While `vblank_i` stays high, no further copy happens; shadow writes made meanwhile wait for the next rising edge of `vblank_i`.
- R5: Each copy sets pending bit 3 (parameters committed) on the same edge.
- R6: A high `evt_i` bit sets its pending bit on that edge: `evt_i[0]` sets bit 0 (frame done), `evt_i[1]` bit 1 (input error), `evt_i[2]` bit 2 (output error), `evt_i[3]` bit 4 (coefficient write error). The pending register is read at 0x220.
- R7: Writing 0x220 clears each pending bit written with 1 and leaves the bits written with 0; an event arriving on the same edge as its clear leaves the bit set.
- R8: `irq_o` is high exactly when bit 0 of the global enable (0x21C) is 1 and some pending bit is 1 with the matching bit of the enable mask (0x228, bits 4:0) also 1.
- R9: Writing 0x0000000A to 0x100 clears all registers, shadow and active; writing any other value there changes nothing. 0x100 reads as 0.
- R10: 0x04 reads `vblank_i` in bit 0 and `irq_o` in bit 1; 0x08 reads pending bits 1, 2, 4 in bits 0, 1, 2; 0x0C reads pending bits 0 and 3 in bits 0 and 1. Writes to these three offsets and reads of unmapped offsets have no effect and return 0 respectively.
- R11: The control word at 0x00 is a plain 32-bit register driven onto `ctrl_o` from the edge after the write, without waiting for blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| vblank_i | input | 1 | Vertical blanking level |
| evt_i | input | 4 | Event pulses: frame done, input error, output error, coefficient write error |
| ctrl_o | output | 32 | Control word |
| act_flat_o | output | (7+N_START)*32 | Active parameter words, word k in bits 32k+31:32k |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the collisions: a shadow write on the very edge of a blanking rise, a clear of a pending bit on the edge its event fires, and a soft reset landing together with a commit. Directed steps drive each of these on a single edge, while the random phase toggles `vblank_i`, events and accesses on independent draws so that such coincidences recur many times. A bench model updates its state in the same priority order stated in the requirements and compares the active words, the interrupt and every read each cycle.

// File: rtl/vrb_pkg.sv
package vrb_pkg;

   localparam int unsigned NSRC      = 5;
   localparam int unsigned ST_FRAME  = 0;
   localparam int unsigned ST_INERR  = 1;
   localparam int unsigned ST_OUTERR = 2;
   localparam int unsigned ST_UPD    = 3;
   localparam int unsigned ST_COEF   = 4;
   localparam int unsigned N_FIXED   = 7;

   function automatic logic [31:0] low_ones(input int unsigned w);
      logic [31:0] r;
      r = '0;
      for (int unsigned i = 0; i < 32; i++) if (i < w) r[i] = 1'b1;
      return r;
   endfunction

   function automatic logic [31:0] pair_mask(input int unsigned w);
      return (low_ones(w) << 16) | low_ones(w);
   endfunction

   function automatic logic [31:0] word_mask(input int unsigned k,
                                             input int unsigned sf_w,
                                             input int unsigned fld_w,
                                             input int unsigned ph_w,
                                             input int unsigned set_w,
                                             input int unsigned st_w);
      if (k < 2)       return low_ones(sf_w);
      else if (k < 5)  return pair_mask(fld_w);
      else if (k == 5) return pair_mask(ph_w);
      else if (k == 6) return pair_mask(set_w);
      else             return low_ones(st_w);
   endfunction

endpackage

// File: rtl/vrb_shadow.sv
module vrb_shadow
   import vrb_pkg::*;
#(
   parameter int unsigned NW      = 11,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned SF_W    = 24,
   parameter int unsigned FIELD_W = 11,
   parameter int unsigned PH_W    = 7,
   parameter int unsigned SET_W   = 4,
   parameter int unsigned START_W = 21
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             srst_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [31:0]      wdata_i,
   input  logic             commit_i,
   output logic [NW*32-1:0] shadow_o,
   output logic [NW*32-1:0] active_o
);

   for (genvar k = 0; k < NW; k++) begin : g_word
      localparam logic [31:0] MASK = word_mask(k, SF_W, FIELD_W, PH_W, SET_W, START_W);
      logic [31:0] shd_q;
      logic [31:0] act_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            shd_q <= '0;
            act_q <= '0;
         end else if (srst_i) begin
            shd_q <= '0;
            act_q <= '0;
         end else begin
            if (wr_en_i && (wr_idx_i == IDX_W'(k))) shd_q <= wdata_i & MASK;
            if (commit_i) act_q <= shd_q;
         end
      end

      assign shadow_o[k*32 +: 32] = shd_q;
      assign active_o[k*32 +: 32] = act_q;
   end

endmodule

// File: rtl/vrb_intc.sv
module vrb_intc #(
   parameter int unsigned NSRC = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            srst_i,
   input  logic [NSRC-1:0] set_i,
   input  logic            clr_we_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic            en_we_i,
   input  logic [NSRC-1:0] en_i,
   input  logic            gie_we_i,
   input  logic            gie_i,
   output logic [NSRC-1:0] pend_o,
   output logic [NSRC-1:0] en_o,
   output logic            gie_o,
   output logic            irq_o
);

   logic [NSRC-1:0] pend_q, en_q;
   logic            gie_q;
   logic [NSRC-1:0] clr_eff;

   assign clr_eff = clr_we_i ? clr_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         en_q   <= '0;
         gie_q  <= 1'b0;
      end else if (srst_i) begin
         pend_q <= '0;
         en_q   <= '0;
         gie_q  <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~clr_eff) | set_i;
         if (en_we_i)  en_q  <= en_i;
         if (gie_we_i) gie_q <= gie_i;
      end
   end

   assign pend_o = pend_q;
   assign en_o   = en_q;
   assign gie_o  = gie_q;
   assign irq_o  = gie_q & (|(pend_q & en_q));

endmodule

// File: rtl/vsync_regbank.sv
module vsync_regbank
   import vrb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned N_START  = 4,
   parameter int unsigned SF_W     = 24,
   parameter int unsigned FIELD_W  = 11,
   parameter int unsigned PH_W     = 7,
   parameter int unsigned SET_W    = 4,
   parameter int unsigned START_W  = 21,
   parameter logic [31:0] SRST_KEY = 32'h0000_000A
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         sel_i,
   input  logic                         wr_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [31:0]                  wdata_i,
   output logic [31:0]                  rdata_o,
   input  logic                         vblank_i,
   input  logic [3:0]                   evt_i,
   output logic [31:0]                  ctrl_o,
   output logic [(7+N_START)*32-1:0]    act_flat_o,
   output logic                         irq_o
);

   localparam int unsigned NW    = N_FIXED + N_START;
   localparam int unsigned IDX_W = $clog2(NW);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h000);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h004);
   localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'('h008);
   localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'('h00C);
   localparam logic [ADDR_W-1:0] A_PBASE = ADDR_W'('h010);
   localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'('h100);
   localparam logic [ADDR_W-1:0] A_GIE   = ADDR_W'('h21C);
   localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'('h220);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'('h228);

   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x228");
   end
   if (N_START < 1 || N_START > 8) begin : g_bad_nstart
      $error("N_START out of range 1..8");
   end
   if (FIELD_W > 16 || PH_W > 16 || SET_W > 16) begin : g_bad_pair
      $error("paired fields must fit in 16 bits");
   end
   if (SF_W > 32 || START_W > 32) begin : g_bad_word
      $error("single fields must fit in 32 bits");
   end

   logic               wr_acc;
   logic               soft_rst;
   logic               vb_q;
   logic               commit;
   logic [ADDR_W-1:0]  pdiff;
   logic               par_hit;
   logic [IDX_W-1:0]   par_idx;
   logic [NW*32-1:0]   shadow_flat;
   logic [NSRC-1:0]    pend, ien;
   logic               gie;
   logic [NSRC-1:0]    ev_set;
   logic [31:0]        ctrl_q;

   assign wr_acc   = sel_i & wr_i;
   assign soft_rst = wr_acc && (addr_i == A_SRST) && (wdata_i == SRST_KEY);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vb_q <= 1'b0;
      else         vb_q <= vblank_i;
   end
   assign commit = vblank_i & ~vb_q;

   assign pdiff   = addr_i - A_PBASE;
   assign par_hit = (addr_i >= A_PBASE) && (pdiff < ADDR_W'(4 * NW)) && (addr_i[1:0] == 2'b00);
   assign par_idx = pdiff[IDX_W+1:2];

   vrb_shadow #(
      .NW(NW), .IDX_W(IDX_W), .SF_W(SF_W), .FIELD_W(FIELD_W),
      .PH_W(PH_W), .SET_W(SET_W), .START_W(START_W)
   ) u_shadow (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .srst_i   (soft_rst),
      .wr_en_i  (wr_acc && par_hit),
      .wr_idx_i (par_idx),
      .wdata_i  (wdata_i),
      .commit_i (commit),
      .shadow_o (shadow_flat),
      .active_o (act_flat_o)
   );

   always_comb begin
      ev_set            = '0;
      ev_set[ST_FRAME]  = evt_i[0];
      ev_set[ST_INERR]  = evt_i[1];
      ev_set[ST_OUTERR] = evt_i[2];
      ev_set[ST_UPD]    = commit;
      ev_set[ST_COEF]   = evt_i[3];
   end

   vrb_intc #(.NSRC(NSRC)) u_intc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .srst_i   (soft_rst),
      .set_i    (ev_set),
      .clr_we_i (wr_acc && addr_i == A_PEND),
      .clr_i    (wdata_i[NSRC-1:0]),
      .en_we_i  (wr_acc && addr_i == A_IEN),
      .en_i     (wdata_i[NSRC-1:0]),
      .gie_we_i (wr_acc && addr_i == A_GIE),
      .gie_i    (wdata_i[0]),
      .pend_o   (pend),
      .en_o     (ien),
      .gie_o    (gie),
      .irq_o    (irq_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ctrl_q <= '0;
      else if (soft_rst)                    ctrl_q <= '0;
      else if (wr_acc && addr_i == A_CTRL)  ctrl_q <= wdata_i;
   end
   assign ctrl_o = ctrl_q;

   always_comb begin
      rdata_o = '0;
      if (par_hit) begin
         rdata_o = shadow_flat[par_idx*32 +: 32];
      end else begin
         case (addr_i)
            A_CTRL: rdata_o = ctrl_q;
            A_STAT: rdata_o = {30'd0, irq_o, vblank_i};
            A_ERR:  rdata_o = {29'd0, pend[ST_COEF], pend[ST_OUTERR], pend[ST_INERR]};
            A_DONE: rdata_o = {30'd0, pend[ST_UPD], pend[ST_FRAME]};
            A_GIE:  rdata_o = {31'd0, gie};
            A_PEND: rdata_o = 32'(pend);
            A_IEN:  rdata_o = 32'(ien);
            default: rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/vrb_checks.sv
module vrb_checks #(
   parameter int unsigned NW = 11
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [3:0]       evt_i,
   input logic             commit,
   input logic             soft_rst,
   input logic [NW*32-1:0] shadow_flat,
   input logic [NW*32-1:0] act_flat_o,
   input logic [4:0]       pend,
   input logic             gie,
   input logic             irq_o
);

   p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit && !soft_rst |=> act_flat_o == $past(shadow_flat));

   p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !commit && !soft_rst |=> $stable(act_flat_o));

   p_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit |=> !commit);

   p_upd_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit && !soft_rst |=> pend[3]);

   p_frame_evt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[0] && !soft_rst |=> pend[0]);

   p_coef_evt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[3] && !soft_rst |=> pend[4]);

   p_gie_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gie |-> !irq_o);

   p_soft_rst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_rst |=> (act_flat_o == '0) && (pend == '0) && !irq_o);

endmodule

bind vsync_regbank vrb_checks #(.NW(NW)) u_vrb_checks (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .evt_i       (evt_i),
   .commit      (commit),
   .soft_rst    (soft_rst),
   .shadow_flat (shadow_flat),
   .act_flat_o  (act_flat_o),
   .pend        (pend),
   .gie         (gie),
   .irq_o       (irq_o)
);

// File: tb/test_vsync_regbank.sv
`timescale 1ns/1ps
module test_vsync_regbank;

   localparam int NW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0, wr = 1'b0, vb = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [3:0]    evt = '0;
   logic [31:0]   rdata, ctrl;
   logic [NW*32-1:0] act;
   logic          irq;

   int n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   vsync_regbank i_vsync_regbank (
      .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .vblank_i(vb), .evt_i(evt),
      .ctrl_o(ctrl), .act_flat_o(act), .irq_o(irq)
   );

   // bench model
   logic [31:0] m_sh [NW];
   logic [31:0] m_act [NW];
   logic [31:0] m_ctrl;
   logic [4:0]  m_pend, m_en;
   logic        m_gie, m_vbq;

   function automatic logic [31:0] fmask(int k);
      if (k < 2)       return 32'h00FF_FFFF;
      else if (k < 5)  return 32'h07FF_07FF;
      else if (k == 5) return 32'h007F_007F;
      else if (k == 6) return 32'h000F_000F;
      else             return 32'h001F_FFFF;
   endfunction

   function automatic logic m_irq();
      return m_gie & (|(m_pend & m_en));
   endfunction

   function automatic logic [31:0] exp_rd(logic [11:0] a, logic v);
      if (a >= 12'h010 && a < 12'h03C && a[1:0] == 2'b00) return m_sh[(a - 12'h010) >> 2];
      case (a)
         12'h000: return m_ctrl;
         12'h004: return {30'd0, m_irq(), v};
         12'h008: return {29'd0, m_pend[4], m_pend[2], m_pend[1]};
         12'h00C: return {30'd0, m_pend[3], m_pend[0]};
         12'h21C: return {31'd0, m_gie};
         12'h220: return {27'd0, m_pend};
         12'h228: return {27'd0, m_en};
         default: return 32'd0;
      endcase
   endfunction

   task automatic model_reset();
      for (int k = 0; k < NW; k++) begin m_sh[k] = '0; m_act[k] = '0; end
      m_ctrl = '0; m_pend = '0; m_en = '0; m_gie = 1'b0;
   endtask

   task automatic check(string tag, logic [NW*32-1:0] got, logic [NW*32-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // one clock cycle of stimulus; called right after a falling edge
   task automatic cyc(bit s, bit w, logic [11:0] a, logic [31:0] d, bit v, logic [3:0] e, string tag);
      logic commit;
      logic [4:0] clr;
      logic [NW*32-1:0] ea;
      sel = s; wr = w; addr = a; wdata = d; vb = v; evt = e;
      #2;
      if (s && !w) check(tag, NW*32'(rdata), NW*32'(exp_rd(a, v)));
      @(posedge clk);
      #1;
      commit = v & ~m_vbq;
      m_vbq  = v;
      if (s && w && a == 12'h100 && d == 32'h0000_000A) begin
         model_reset();
      end else begin
         if (commit) for (int k = 0; k < NW; k++) m_act[k] = m_sh[k];
         clr = (s && w && a == 12'h220) ? d[4:0] : 5'd0;
         m_pend = (m_pend & ~clr) | {e[3], commit, e[2:0]};
         if (s && w) begin
            if (a == 12'h000) m_ctrl = d;
            if (a == 12'h21C) m_gie = d[0];
            if (a == 12'h228) m_en = d[4:0];
            if (a >= 12'h010 && a < 12'h03C && a[1:0] == 2'b00)
               m_sh[(a - 12'h010) >> 2] = d & fmask((a - 12'h010) >> 2);
         end
      end
      for (int k = 0; k < NW; k++) ea[k*32 +: 32] = m_act[k];
      check("R3 active words", act, ea);
      check("R8 irq", NW*32'(irq), NW*32'(m_irq()));
      check("R11 ctrl", NW*32'(ctrl), NW*32'(m_ctrl));
      @(negedge clk);
   endtask

   task automatic wreg(logic [11:0] a, logic [31:0] d); cyc(1, 1, a, d, vb, 4'd0, "R2"); endtask
   task automatic rreg(logic [11:0] a, string tag);     cyc(1, 0, a, '0, vb, 4'd0, tag); endtask
   task automatic idle(logic v, logic [3:0] e);           cyc(0, 0, '0, '0, v, e, "idle"); endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   logic [11:0] pick [14] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                              12'h018, 12'h024, 12'h028, 12'h038, 12'h21C, 12'h220,
                              12'h228, 12'h100};

   initial begin
      model_reset();
      m_vbq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rreg(12'h000, "R1"); rreg(12'h010, "R1"); rreg(12'h220, "R1");
      rreg(12'h228, "R1"); rreg(12'h21C, "R1"); rreg(12'h038, "R1");

      // R2: masked readback, all ones
      for (int k = 0; k < NW; k++) wreg(12'h010 + 12'(4*k), 32'hFFFF_FFFF);
      for (int k = 0; k < NW; k++) rreg(12'h010 + 12'(4*k), "R2");
      rreg(12'h03C, "R10 unmapped");

      // R3 / R5: commit on blanking rise
      idle(1, 0);
      rreg(12'h00C, "R5");
      // R4: held high, write waits
      wreg(12'h018, 32'h0123_0456);
      idle(1, 0); idle(1, 0);
      idle(0, 0);
      // R3: write on the rising edge itself goes to next frame
      cyc(1, 1, 12'h014, 32'h00AB_CDEF, 1, 4'd0, "R3");
      idle(0, 0);
      idle(1, 0);

      // R6 / R7: events, clear, collision
      idle(0, 4'b1111);
      rreg(12'h220, "R6");
      rreg(12'h008, "R10");
      wreg(12'h220, 32'h0000_0005);
      rreg(12'h220, "R7");
      cyc(1, 1, 12'h220, 32'h0000_001F, 0, 4'b0010, "R7");
      rreg(12'h220, "R7");

      // R8: gating
      wreg(12'h228, 32'h0000_0002);
      rreg(12'h004, "R8");
      wreg(12'h21C, 32'h0000_0001);
      rreg(12'h004, "R8");
      wreg(12'h228, 32'h0000_0001);
      rreg(12'h004, "R8");

      // R10: read-only views ignore writes
      wreg(12'h008, 32'hFFFF_FFFF);
      wreg(12'h00C, 32'hFFFF_FFFF);
      rreg(12'h220, "R10");

      // R11: control immediate
      wreg(12'h000, 32'hDEAD_BEEF);

      // R9: wrong key ignored, right key with commit on same edge
      wreg(12'h100, 32'h0000_000B);
      rreg(12'h01C, "R9");
      idle(0, 0);
      cyc(1, 1, 12'h100, 32'h0000_000A, 1, 4'd0, "R9");
      rreg(12'h000, "R9"); rreg(12'h220, "R9"); rreg(12'h01C, "R9"); rreg(12'h100, "R9");

      // random phase
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 4000; i++) begin
         logic [11:0] a;
         logic [31:0] d;
         bit s, w, v;
         a = pick[$urandom_range(0, 13)];
         d = $urandom();
         if (a == 12'h100) d = ($urandom_range(0, 7) == 0) ? 32'h0000_000A : 32'h0000_000C;
         s = ($urandom_range(0, 2) != 0);
         w = $urandom_range(0, 1);
         v = ($urandom_range(0, 5) == 0) ? ~vb : vb;
         cyc(s, w, a, d, v, 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)), "R6 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule